// File: doc/BRIEF.md
# Prescaled Dual-Mode PWM Channel

This block generates one pulse-width-modulated output from a system clock. The clock first passes through an 8-bit prescaler and then a coded divider, and the result forms a tick. A 16-bit down-counter consumes one tick per step. A period therefore spans (period value + 1) ticks. The output is high for (compare value + 1) of those ticks, or for the whole period when compare is not below period. An invert bit flips the whole waveform. A single-cycle strobe marks the end of each period.

Software programs five small registers through a plain write port and a combinational read port. A control register holds enable, invert and mode. Continuous mode reloads the counter forever. One-shot mode runs a single period and then stops. New period and compare values are held in staging registers and reach the running counter only at a period boundary, so a rewrite in mid-period cannot cause a glitch.

Top module: `pwm_chan`

## Requirements
- R1: After reset, pwm_o and period_end_o are low and every register reads back 0.
- R2: Register addresses: 0 prescale [7:0]; 1 divider select [2:0]; 2 control with enable at bit 0, invert at bit 2 and mode at bit 3 (1 = continuous, 0 = one-shot); 3 period [15:0]; 4 compare [15:0]. Reads return the stored fields, with all other bits 0.
- R3: One tick lasts N = (prescale + 1) × divider clocks. Consecutive period-end strobes in continuous mode are (period + 1) × N clocks apart.
- R4: Divider select codes map 0→2, 1→4, 2→8, 3→16 and 4→1. Codes 5 to 7 produce no ticks, so no strobe appears.
- R5: When compare < period, the output is high for (compare + 1) × N clocks of each period.
- R6: When compare ≥ period, the output is high for the whole period.
- R7: With invert set, the output is the complement of the non-inverted waveform. While the channel is disabled, the output equals the invert bit.
- R8: A period value of 0 stops the channel: there is no strobe, and the output stays low (high when inverted).
- R9: In one-shot mode, the channel runs exactly one period after enable rises, gives one strobe, and then holds the output low.
- R10: period_end_o is high for one clock at the end of each period.
- R11: The running period and compare values are loaded when enable rises and at each period end. A write in mid-period does not change the current period.
- R12: Clearing enable stops the counter within one clock. After that, no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 16 | Read data, combinational |
| pwm_o | output | 1 | PWM waveform |
| period_end_o | output | 1 | One-clock strobe at each period end |

## Verification
A wrong tick divider or a wrong counter load shows up as a wrong spacing between strobes, or as a wrong count of high clocks in the very next period. The bench measures both quantities per period. A shadow value applied too early changes the high count before the next strobe, so the bench counts outputs between a mid-period write and that strobe. A stuck run state shows up within one or two clocks as a missing or extra strobe, or as an output that does not follow the invert bit.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DSEL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd4;

  localparam int DSEL_W = 3;
  localparam int DIV_W  = 5;

  typedef struct packed {
    logic cont;
    logic inv;
    logic en;
  } ctrl_t;

  // divide factor for a selector code; 0 marks an illegal code
  function automatic logic [DIV_W-1:0] div_factor(input logic [DSEL_W-1:0] code);
    case (code)
      3'd0:    div_factor = 5'd2;
      3'd1:    div_factor = 5'd4;
      3'd2:    div_factor = 5'd8;
      3'd3:    div_factor = 5'd16;
      3'd4:    div_factor = 5'd1;
      default: div_factor = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic [PSC_W-1:0]   psc_o,
  output logic [DSEL_W-1:0]  dsel_o,
  output ctrl_t              ctrl_o,
  output logic [CNT_W-1:0]   per_o,
  output logic [CNT_W-1:0]   cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_o  <= '0;
      dsel_o <= '0;
      ctrl_o <= '0;
      per_o  <= '0;
      cmp_o  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_PSC:  psc_o  <= wr_data_i[PSC_W-1:0];
        A_DSEL: dsel_o <= wr_data_i[DSEL_W-1:0];
        A_CTRL: ctrl_o <= '{cont: wr_data_i[3], inv: wr_data_i[2], en: wr_data_i[0]};
        A_PER:  per_o  <= wr_data_i;
        A_CMP:  cmp_o  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_PSC:  rd_data_o[PSC_W-1:0]  = psc_o;
      A_DSEL: rd_data_o[DSEL_W-1:0] = dsel_o;
      A_CTRL: rd_data_o[3:0]        = {ctrl_o.cont, ctrl_o.inv, 1'b0, ctrl_o.en};
      A_PER:  rd_data_o             = per_o;
      A_CMP:  rd_data_o             = cmp_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwm_chan_div.sv
module pwm_chan_div
  import pwm_chan_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [DSEL_W-1:0] dsel_i,
  output logic              tick_o
);
  localparam int DCNT_W = DIV_W - 1;

  logic [PSC_W-1:0]  psc_cnt_q;
  logic [DCNT_W-1:0] div_cnt_q;
  logic [DIV_W-1:0]  div;
  logic              legal, pre_tick, div_last;

  assign div      = div_factor(dsel_i);
  assign legal    = (div != '0);
  // >= so that lowering the prescale in mid-run cannot strand the counter
  assign pre_tick = run_i && (psc_cnt_q >= psc_i);
  assign div_last = ({1'b0, div_cnt_q} >= (div - 1'b1));
  assign tick_o   = pre_tick && legal && div_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (!run_i) begin
      psc_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_tick) begin
      psc_cnt_q <= '0;
      div_cnt_q <= div_last ? '0 : div_cnt_q + 1'b1;
    end else begin
      psc_cnt_q <= psc_cnt_q + 1'b1;
    end
  end

  assert_idle_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> psc_cnt_q == '0);
  assert_div_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) && !$past(pre_tick) |-> $stable(div_cnt_q));
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             pwm_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q, aper_q, acmp_q;
  logic             en_q, run_q, end_q;
  logic             start, wrap, raw;

  assign start = ctrl_i.en && !en_q;
  assign wrap  = run_q && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      end_q  <= 1'b0;
      cnt_q  <= '0;
      aper_q <= '0;
      acmp_q <= '0;
    end else begin
      en_q  <= ctrl_i.en;
      end_q <= 1'b0;
      if (!ctrl_i.en) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (start) begin
        run_q  <= (per_i != '0);
        cnt_q  <= per_i;
        aper_q <= per_i;
        acmp_q <= cmp_i;
      end else if (wrap) begin
        end_q <= 1'b1;
        if (!ctrl_i.cont || per_i == '0) begin
          run_q <= 1'b0;
        end else begin
          cnt_q  <= per_i;
          aper_q <= per_i;
          acmp_q <= cmp_i;
        end
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // high while cnt is in the top (acmp+1) steps of the period
  assign raw   = run_q && ((acmp_q >= aper_q) || (cnt_q >= aper_q - acmp_q));
  assign pwm_o = raw ^ ctrl_i.inv;
  assign run_o = run_q;
  assign end_o = end_q;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= aper_q);
  assert_nonzero_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> aper_q != '0);
  assert_strobe_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
  assert_shadow_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && !end_q |-> $stable(aper_q) && $stable(acmp_q));
  assert_stop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |=> !run_q && !end_q);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             pwm_o,
  output logic             period_end_o
);
  logic [PSC_W-1:0]  psc;
  logic [DSEL_W-1:0] dsel;
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  per, cmp;
  logic              run, tick;

  pwm_chan_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .psc_o(psc), .dsel_o(dsel), .ctrl_o(ctrl), .per_o(per), .cmp_o(cmp)
  );

  pwm_chan_div #(.PSC_W(PSC_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .psc_i(psc), .dsel_i(dsel), .tick_o(tick)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .per_i(per), .cmp_i(cmp), .tick_i(tick),
    .run_o(run), .pwm_o, .end_o(period_end_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !period_end_o);
endmodule

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm, pend;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm_chan u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwm_o(pwm), .period_end_o(pend)
  );

  typedef struct packed {
    logic [7:0]  psc;
    logic [2:0]  dsel;
    logic [15:0] per;
    logic [15:0] cmp;
    logic        inv;
    int          tot;
    int          hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   3'd4, 16'd9,  16'd3,  1'b0, 10,  4},
    '{8'd0,   3'd4, 16'd9,  16'd9,  1'b0, 10,  10},
    '{8'd0,   3'd4, 16'd9,  16'd20, 1'b0, 10,  10},
    '{8'd1,   3'd4, 16'd4,  16'd1,  1'b0, 10,  4},
    '{8'd0,   3'd0, 16'd3,  16'd0,  1'b0, 8,   2},
    '{8'd2,   3'd1, 16'd2,  16'd1,  1'b0, 36,  24},
    '{8'd0,   3'd4, 16'd9,  16'd3,  1'b1, 10,  6},
    '{8'd0,   3'd3, 16'd1,  16'd0,  1'b0, 32,  16},
    '{8'd255, 3'd4, 16'd1,  16'd0,  1'b0, 512, 256}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // waits for a strobe, then counts samples and highs up to the next strobe
  task automatic measure(output int tot, output int hi);
    int guard = 0;
    tot = 0; hi = 0;
    while (!pend && guard < 5000) begin @(negedge clk); guard++; end
    do begin
      tot++;
      if (pwm) hi++;
      @(negedge clk); guard++;
    end while (!pend && guard < 5000);
    if (guard >= 5000) tot = -1;
  endtask

  task automatic window(input int n, output int strobes, output int hi);
    strobes = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pend) strobes++;
      if (pwm) hi++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, tot, hi, st;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_o", int'(pwm), 0);
    chk("R1 period_end_o", int'(pend), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", v, 0);
    end

    // R2 field widths, R7 disabled output follows invert
    wr(3'd0, 16'h01FF); rd(3'd0, v); chk("R2 prescale", v, 16'hFF);
    wr(3'd1, 16'hFFFD); rd(3'd1, v); chk("R2 divsel", v, 5);
    wr(3'd2, 16'hFFF6); rd(3'd2, v); chk("R2 control", v, 4);
    chk("R7 disabled inverted", int'(pwm), 1);
    wr(3'd2, 16'h0000);
    chk("R7 disabled plain", int'(pwm), 0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(3'd2, 16'h0);
      wr(3'd0, {8'd0, VECS[i].psc});
      wr(3'd1, {13'd0, VECS[i].dsel});
      wr(3'd3, VECS[i].per);
      wr(3'd4, VECS[i].cmp);
      wr(3'd2, {12'd0, 1'b1, VECS[i].inv, 2'b01});
      measure(tot, hi);
      chk("R3 R4 period clocks", tot, VECS[i].tot);
      chk("R5 R6 R7 high clocks", hi, VECS[i].hi);
    end

    // R11 shadow: compare rewrite in mid-period waits for the boundary
    wr(3'd2, 16'h0);
    wr(3'd0, 16'd0); wr(3'd1, 16'd4); wr(3'd3, 16'd9); wr(3'd4, 16'd3);
    wr(3'd2, 16'h0009);
    measure(tot, hi);
    repeat (5) @(negedge clk);
    wr(3'd4, 16'd8);
    hi = 0;
    while (!pend) begin
      if (pwm) hi++;
      @(negedge clk);
    end
    chk("R11 no early compare", hi, 0);
    measure(tot, hi);
    chk("R11 new compare high", hi, 9);
    chk("R10 R11 period", tot, 10);

    // R12 clearing enable stops at once
    wr(3'd2, 16'h0);
    @(negedge clk);
    chk("R12 output inactive", int'(pwm), 0);
    window(40, st, hi);
    chk("R12 no strobe", st, 0);
    chk("R12 output low", hi, 0);

    // R9 one-shot
    wr(3'd3, 16'd4); wr(3'd4, 16'd1);
    wr(3'd2, 16'h0001);
    window(60, st, hi);
    chk("R9 one strobe", st, 1);
    chk("R9 one high run", hi, 2);
    chk("R9 ends low", int'(pwm), 0);

    // R4 illegal selector code
    wr(3'd2, 16'h0);
    wr(3'd1, 16'd5); wr(3'd3, 16'd3);
    wr(3'd2, 16'h0009);
    window(100, st, hi);
    chk("R4 illegal code no strobe", st, 0);

    // R8 zero period
    wr(3'd2, 16'h0);
    wr(3'd1, 16'd4); wr(3'd3, 16'd0);
    wr(3'd2, 16'h0009);
    window(40, st, hi);
    chk("R8 no strobe", st, 0);
    chk("R8 output low", hi, 0);
    wr(3'd2, 16'h0);
    wr(3'd2, 16'h000D);
    window(40, st, hi);
    chk("R8 inverted high", hi, 40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule